// File: doc/BRIEF.md
# Byte-Aligned DMA Burst Splitter

This block sits between a DMA engine and a master bus port. It accepts transfer segments, each given as a byte address, a byte length, a direction and a flag that marks the final segment of a logical stream. It cuts each segment into bus bursts of 64-bit beats. No burst crosses a 32-byte aligned block. Each burst carries a 32-bit byte-enable vector, eight lanes per beat, so a segment can start and end on any byte.

Bursts are issued with a valid/ready handshake. Each burst completes later with a one-cycle acknowledge pulse, and acknowledges arrive in issue order. A parameter caps how many bursts may be issued but not yet acknowledged. Issue stalls at the cap and resumes as acknowledges return. Several segments chained under one final flag form one gather or scatter stream. A single completion pulse marks the end of that stream, and it comes only once every burst of the stream has been acknowledged.

Top module: `dma_burst_splitter`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_req_valid` and `xfer_done` are low. `seg_ready` is high in the first cycle after reset.
- R2: `bus_req_addr` is the current byte address rounded down to a multiple of 8. `bus_req_beats` (1 to 4) counts the 8-byte beats from that address up to the nearer of the next 32-byte boundary and the segment end, so the burst stays inside one 32-byte block.
- R3: Bit 8*k+i of `bus_req_be` is set exactly when byte `bus_req_addr + 8*k + i` lies inside the part of the segment that this burst covers. All bits of beats at or beyond `bus_req_beats` are zero.
- R4: The bursts of a segment are issued in ascending address order. Each burst starts where the previous one ended, and their byte enables cover the segment exactly once.
- R5: At most `MAX_OUT` bursts are issued but not yet acknowledged (default 2). `bus_req_valid` is low while that many are outstanding.
- R6: While `bus_req_valid` is high and `bus_req_ready` is low, the request stays valid in the next cycle with the same address, beat count, byte enables and direction.
- R7: A segment of length zero is accepted and produces no bus request.
- R8: `xfer_done` pulses for one cycle once per stream. The stream's final segment must have been accepted and all its bursts acknowledged, and nothing may be outstanding when the pulse occurs. A zero-length final segment with nothing outstanding still produces the pulse.
- R9: `seg_ready` is low while a segment still has bursts to issue, and from the acceptance of a final segment until its `xfer_done` pulse. `bus_req_valid` is never high while `seg_ready` is high.
- R10: `bus_req_write` equals the `seg_write` value of the segment the burst belongs to.
- R11: Address bits above bit 31 are carried unchanged when `ADDR_W` is 36.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment can be accepted |
| seg_addr | input | ADDR_W | Segment start byte address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_write | input | 1 | 1 = write to memory, 0 = read |
| seg_last | input | 1 | Final segment of the stream |
| bus_req_valid | output | 1 | Burst request valid |
| bus_req_ready | input | 1 | Bus accepts the request |
| bus_req_addr | output | ADDR_W | 8-byte aligned address of the first beat |
| bus_req_beats | output | 3 | Beat count, 1 to 4 |
| bus_req_be | output | 32 | Byte enables, 8 per beat, beat 0 in bits 7:0 |
| bus_req_write | output | 1 | Burst direction |
| bus_ack | input | 1 | One burst completed (in order) |
| xfer_done | output | 1 | Stream complete pulse |

## Verification
The assertions check on every cycle that each burst stays inside one 32-byte block, and that byte enables beyond the beat count are clear. They also check that requests hold while stalled, that the outstanding count never exceeds the cap and issue stops at it, that completion occurs only with nothing outstanding, and that no request is offered while a new segment can be taken. Other properties are left to the bench scenarios, which compare every burst with an independent byte-level model:

- the exact split points and lane masks of unaligned spans;
- contiguous address order across a segment;
- the skipping of zero-length segments in the middle or at the end of a gather chain;
- high address bits;
- a single completion pulse per stream.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
    localparam int BEAT_BYTES  = 8;
    localparam int BLOCK_BYTES = 32;
    localparam int MAX_BEATS   = BLOCK_BYTES / BEAT_BYTES;
    localparam int BE_W        = BLOCK_BYTES;
    localparam int OFF_W       = $clog2(BLOCK_BYTES) + 1;
    localparam int BEATS_W     = $clog2(MAX_BEATS) + 1;
endpackage

// File: rtl/dsb_lane_mask.sv
module dsb_lane_mask
    import dsb_pkg::*;
(
    input  logic [OFF_W-1:0]      beat_off,
    input  logic [OFF_W-1:0]      lo,
    input  logic [OFF_W-1:0]      hi,
    output logic [BEAT_BYTES-1:0] mask
);
    always_comb begin
        for (int i = 0; i < BEAT_BYTES; i++) begin
            mask[i] = (({1'b0, beat_off} + (OFF_W+1)'(i)) >= {1'b0, lo}) &&
                      (({1'b0, beat_off} + (OFF_W+1)'(i)) <  {1'b0, hi});
        end
    end
endmodule

// File: rtl/dsb_burst_calc.sv
module dsb_burst_calc
    import dsb_pkg::*;
#(
    parameter int AW = 32,
    localparam int EW = AW + 1
) (
    input  logic [EW-1:0]      cur,
    input  logic [EW-1:0]      stop,
    output logic [AW-1:0]      base,
    output logic [BEATS_W-1:0] beats,
    output logic [BE_W-1:0]    be,
    output logic [EW-1:0]      next_cur,
    output logic               final_burst
);
    logic [EW-1:0]    blk_start;
    logic [EW-1:0]    blk_end;
    logic [EW-1:0]    burst_end;
    logic [OFF_W-1:0] lo;
    logic [OFF_W-1:0] hi;
    logic [OFF_W-1:0] first_off;
    logic [OFF_W-1:0] span;

    always_comb begin
        blk_start   = {cur[EW-1:5], 5'b0};
        blk_end     = blk_start + EW'(BLOCK_BYTES);
        burst_end   = (stop < blk_end) ? stop : blk_end;
        base        = {cur[AW-1:3], 3'b0};
        lo          = {1'b0, cur[4:0]};
        hi          = OFF_W'(burst_end - blk_start);
        first_off   = {1'b0, cur[4:3], 3'b000};
        span        = hi - first_off;
        beats       = BEATS_W'((span + OFF_W'(BEAT_BYTES - 1)) >> 3);
        next_cur    = burst_end;
        final_burst = (burst_end == stop);
    end

    for (genvar k = 0; k < MAX_BEATS; k++) begin : g_lane
        localparam logic [OFF_W-1:0] STEP = OFF_W'(k * BEAT_BYTES);
        dsb_lane_mask u_mask (
            .beat_off (first_off + STEP),
            .lo       (lo),
            .hi       (hi),
            .mask     (be[k*BEAT_BYTES +: BEAT_BYTES])
        );
    end
endmodule

// File: rtl/dsb_flight_ctr.sv
module dsb_flight_ctr #(
    parameter int MAX_OUT = 2,
    localparam int CW = $clog2(MAX_OUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic full,
    output logic empty
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec)      cnt_d = cnt_q + CW'(1);
        else if (dec && !inc) cnt_d = cnt_q - CW'(1);
        full  = (cnt_q == CW'(MAX_OUT));
        empty = (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dma_burst_splitter.sv
module dma_burst_splitter
    import dsb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int MAX_OUT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seg_valid,
    output logic               seg_ready,
    input  logic [ADDR_W-1:0]  seg_addr,
    input  logic [LEN_W-1:0]   seg_len,
    input  logic               seg_write,
    input  logic               seg_last,
    output logic               bus_req_valid,
    input  logic               bus_req_ready,
    output logic [ADDR_W-1:0]  bus_req_addr,
    output logic [BEATS_W-1:0] bus_req_beats,
    output logic [BE_W-1:0]    bus_req_be,
    output logic               bus_req_write,
    input  logic               bus_ack,
    output logic               xfer_done
);
    localparam int EW = ADDR_W + 1;

    typedef struct packed {
        logic          active;
        logic [EW-1:0] cur;
        logic [EW-1:0] stop;
        logic          write;
        logic          last_seg;
        logic          last_pend;
        logic          done;
    } state_t;

    state_t st_d, st_q;

    logic          cap_full, none_out;
    logic          accept, issue;
    logic [EW-1:0] next_cur;
    logic          final_burst;

    dsb_burst_calc #(.AW(ADDR_W)) u_calc (
        .cur         (st_q.cur),
        .stop        (st_q.stop),
        .base        (bus_req_addr),
        .beats       (bus_req_beats),
        .be          (bus_req_be),
        .next_cur    (next_cur),
        .final_burst (final_burst)
    );

    dsb_flight_ctr #(.MAX_OUT(MAX_OUT)) u_flight (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (issue),
        .dec   (bus_ack),
        .full  (cap_full),
        .empty (none_out)
    );

    always_comb begin
        seg_ready     = !st_q.active && !st_q.last_pend;
        bus_req_valid = st_q.active && !cap_full;
        bus_req_write = st_q.write;
        xfer_done     = st_q.done;
        accept        = seg_valid && seg_ready;
        issue         = bus_req_valid && bus_req_ready;

        st_d      = st_q;
        st_d.done = 1'b0;

        if (accept) begin
            if (seg_len == '0) begin
                st_d.last_pend = seg_last;
            end else begin
                st_d.active   = 1'b1;
                st_d.cur      = {1'b0, seg_addr};
                st_d.stop     = {1'b0, seg_addr} + EW'(seg_len);
                st_d.write    = seg_write;
                st_d.last_seg = seg_last;
            end
        end

        if (issue) begin
            st_d.cur = next_cur;
            if (final_burst) begin
                st_d.active = 1'b0;
                if (st_q.last_seg) st_d.last_pend = 1'b1;
            end
        end

        if (st_q.last_pend && !st_q.active && none_out) begin
            st_d.done      = 1'b1;
            st_d.last_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dsb_checker.sv
module dsb_checker #(
    parameter int MAX_OUT = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        seg_ready,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_addr_lo,
    input logic [2:0]  req_beats,
    input logic [31:0] req_be,
    input logic        req_write,
    input logic        ack,
    input logic        done
);
    logic [7:0] ck_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) ck_cnt <= '0;
        else        ck_cnt <= ck_cnt + 8'(req_valid && req_ready) - 8'(ack);
    end

    assert_in_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_beats != 3'd0) &&
                      (({2'b00, req_addr_lo} + {1'b0, req_beats}) <= 4'd4));

    assert_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_be >> {req_beats, 3'b000}) == 32'd0) && (req_be[7:0] != 8'd0));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ck_cnt <= 8'(MAX_OUT));

    assert_stall_at_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_cnt == 8'(MAX_OUT)) |-> !req_valid);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid && $stable(req_addr_lo) &&
            $stable(req_beats) && $stable(req_be) && $stable(req_write));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ck_cnt == 8'd0));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seg_ready |-> !req_valid);
endmodule

bind dma_burst_splitter dsb_checker #(.MAX_OUT(MAX_OUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .seg_ready   (seg_ready),
    .req_valid   (bus_req_valid),
    .req_ready   (bus_req_ready),
    .req_addr_lo (bus_req_addr[4:3]),
    .req_beats   (bus_req_beats),
    .req_be      (bus_req_be),
    .req_write   (bus_req_write),
    .ack         (bus_ack),
    .done        (xfer_done)
);

// File: tb/dma_burst_splitter_tb_top.sv
module dma_burst_splitter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 36;
    localparam int LW = 16;
    localparam int MO = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seg_valid = 1'b0, seg_write = 1'b0, seg_last = 1'b0;
    logic [AW-1:0] seg_addr = '0;
    logic [LW-1:0] seg_len = '0;
    logic seg_ready;
    logic bus_req_valid, bus_req_write, xfer_done;
    logic bus_req_ready = 1'b0, bus_ack = 1'b0;
    logic [AW-1:0] bus_req_addr;
    logic [2:0] bus_req_beats;
    logic [31:0] bus_req_be;

    typedef struct {
        logic [AW-1:0] addr;
        int            beats;
        logic [31:0]   be;
        logic          wr;
    } burst_t;

    burst_t sb[$];
    int checks = 0, errors = 0, pend = 0, done_cnt = 0, cap_hits = 0;
    bit awaiting = 0;
    int rdy_mode = 0, ack_mode = 0;
    bit hold_low = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic prev_stall = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [31:0] prev_be = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_burst_splitter #(.ADDR_W(AW), .LEN_W(LW), .MAX_OUT(MO)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_write(seg_write), .seg_last(seg_last),
        .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
        .bus_req_addr(bus_req_addr), .bus_req_beats(bus_req_beats),
        .bus_req_be(bus_req_be), .bus_req_write(bus_req_write),
        .bus_ack(bus_ack), .xfer_done(xfer_done)
    );

    task automatic chk(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Byte-level model of the expected bursts of one segment
    task automatic model(input longint a, input int len, input bit wr);
        longint cur = a;
        longint e = a + len;
        while (cur < e) begin
            burst_t b;
            longint blk = (cur | 64'd31) + 1;
            longint bend = (blk < e) ? blk : e;
            longint base = cur & ~64'd7;
            b.addr = AW'(base);
            b.beats = int'((bend - base + 7) / 8);
            b.be = '0;
            for (int j = 0; j < 32; j++)
                if (base + j >= cur && base + j < bend) b.be[j] = 1'b1;
            b.wr = wr;
            sb.push_back(b);
            cur = bend;
        end
    endtask

    task automatic send_seg(input longint a, input int len, input bit wr, input bit last);
        @(posedge clk); #1;
        seg_valid = 1'b1;
        seg_addr = AW'(a);
        seg_len = LW'(len);
        seg_write = wr;
        seg_last = last;
        do @(negedge clk); while (!seg_ready);
        @(posedge clk); #1;
        seg_valid = 1'b0;
        model(a, len, wr);
        if (last) awaiting = 1'b1;
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        while (awaiting && t < 5000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        chk(!awaiting, "R8", $sformatf("%s completion act=%0d exp=1", tag, !awaiting));
        chk(sb.size() == 0, "R4", $sformatf("%s bursts left act=%0d exp=0", tag, sb.size()));
    endtask

    // Bus-side responder: ready and acknowledge patterns
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bus_req_ready = !hold_low && ((rdy_mode == 0) || lfsr[0] || lfsr[3]);
        bus_ack = (pend > 0) && ((ack_mode == 0) || (lfsr[1] && lfsr[4] && lfsr[6]));
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (xfer_done) begin
                chk(awaiting && sb.size() == 0 && pend == 0, "R8",
                    $sformatf("done with awaiting=%0d left=%0d pend=%0d exp 1/0/0",
                              awaiting, sb.size(), pend));
                awaiting = 1'b0;
                done_cnt++;
            end
            if (seg_ready && (sb.size() != 0 || awaiting))
                chk(1'b0, "R9", $sformatf("seg_ready=1 with %0d bursts left awaiting=%0d exp ready=0",
                                          sb.size(), awaiting));
            if (prev_stall)
                chk(bus_req_valid && bus_req_addr == prev_addr && bus_req_be == prev_be, "R6",
                    $sformatf("held req act valid=%0d addr=%h be=%h exp 1/%h/%h",
                              bus_req_valid, bus_req_addr, bus_req_be, prev_addr, prev_be));
            if (pend == MO) begin
                cap_hits++;
                if (bus_req_valid)
                    chk(1'b0, "R5", $sformatf("valid at cap act=1 exp=0 pend=%0d", pend));
            end
            if (bus_req_valid && bus_req_ready) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R7", $sformatf("unexpected burst addr=%h exp none", bus_req_addr));
                end else begin
                    burst_t e;
                    e = sb.pop_front();
                    chk(bus_req_addr == e.addr && int'(bus_req_beats) == e.beats, "R2",
                        $sformatf("addr/beats act=%h/%0d exp=%h/%0d",
                                  bus_req_addr, bus_req_beats, e.addr, e.beats));
                    chk(bus_req_be == e.be, "R3",
                        $sformatf("be act=%h exp=%h", bus_req_be, e.be));
                    chk(bus_req_write == e.wr, "R10",
                        $sformatf("dir act=%0d exp=%0d", bus_req_write, e.wr));
                end
            end
            prev_stall = bus_req_valid && !bus_req_ready;
            prev_addr = bus_req_addr;
            prev_be = bus_req_be;
            if (bus_ack) pend--;
            if (bus_req_valid && bus_req_ready) pend++;
            if (pend > MO)
                chk(1'b0, "R5", $sformatf("outstanding act=%0d exp<=%0d", pend, MO));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run act=hung exp=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_req_valid && !xfer_done, "R1",
            $sformatf("in reset valid/done act=%0d/%0d exp=0/0", bus_req_valid, xfer_done));
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(seg_ready && !bus_req_valid && !xfer_done, "R1",
            $sformatf("after reset ready/valid/done act=%0d/%0d/%0d exp=1/0/0",
                      seg_ready, bus_req_valid, xfer_done));

        // aligned 64 bytes, write
        send_seg(64'h1000, 64, 1'b1, 1'b1);
        wait_done("R2 aligned");
        // unaligned inside one beat, read
        send_seg(64'h1003, 5, 1'b0, 1'b1);
        wait_done("R3 small");
        // crossing two block boundaries
        send_seg(64'h101D, 40, 1'b1, 1'b1);
        wait_done("R4 split");
        // gather chain with a zero-length middle segment
        send_seg(64'h2006, 13, 1'b0, 1'b0);
        send_seg(64'h3000, 0, 1'b0, 1'b0);
        send_seg(64'h4011, 70, 1'b0, 1'b1);
        wait_done("R7 gather");
        // high address bits
        send_seg(64'h9_8765_43E5, 50, 1'b1, 1'b1);
        wait_done("R11 high");
        chk(done_cnt == 5, "R8", $sformatf("done pulses act=%0d exp=5", done_cnt));

        // stalls on ready and slow acknowledges
        rdy_mode = 1; ack_mode = 1;
        send_seg(64'h5002, 200, 1'b1, 1'b0);
        send_seg(64'h6FF9, 77, 1'b1, 1'b1);
        wait_done("R5 slow");
        hold_low = 1'b1;
        send_seg(64'h7004, 30, 1'b0, 1'b1);
        repeat (6) @(negedge clk);
        chk(bus_req_valid, "R6", $sformatf("stalled valid act=%0d exp=1", bus_req_valid));
        hold_low = 1'b0;
        wait_done("R6 hold");
        chk(cap_hits > 0, "R5", $sformatf("cap reached act=%0d exp>0", cap_hits));

        // zero-length final segment alone
        rdy_mode = 0; ack_mode = 0;
        send_seg(64'h8000, 0, 1'b1, 1'b1);
        wait_done("R7 empty");
        chk(done_cnt == 8, "R8", $sformatf("done pulses act=%0d exp=8", done_cnt));
        repeat (5) @(negedge clk);
        chk(pend == 0 && !bus_req_valid, "R9",
            $sformatf("idle pend/valid act=%0d/%0d exp=0/0", pend, bus_req_valid));

        summary();
        $finish;
    end
endmodule